// File: doc/BRIEF.md
# Single-Segment DMA Sequencer for an SD Host

The block is the register front end and beat sequencer of a small DMA engine. It moves block data between an SD host's data buffer and system memory over one contiguous segment. Software first programs a mode word, a 64-bit start address written as two 32-bit halves, and a transfer length counted in beats. A self-clearing start bit then launches the transfer. The engine issues one request per beat on a valid/ready interface toward memory. After the last accepted beat it raises a sticky completion flag.

Either direction of movement runs through the same engine. Each direction has its own channel soft reset. A channel is held in reset while its bit is cleared and is released when the bit is set. Clearing the bit of the running direction stops the transfer at once. The completion flag is raised in that case too, so an abort looks to software like an early end.

Top module: `sdma_ctrl`

## Requirements
- R1: After reset the mode, address, length and status registers read 0, the channel reset register (index 2) reads 0x300 with both channels released, `mem_req_valid` is low and `xfer_done` is low.
- R2: Register index 0 holds the mode. Bits 17:16 are the direction (0 memory to card, 1 card to memory, 2 and 3 reserved). Bits 5:4 are the beat width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit). Bit 0 set means the address increments, clear means it stays fixed. All other bits read 0.
- R3: Index 3 holds the low address word, index 4 the high word, and index 5 the 16-bit beat count. Each reads back as written.
- R4: Writing 1 to bit 0 of index 1 starts a transfer. `mem_req_valid` is high from the cycle after that write's clock edge. Bit 0 of index 1 reads 1 while the transfer runs and reads 0 by itself once it ends.
- R5: A transfer issues exactly the programmed number of beats. A beat is a cycle with `mem_req_valid` and `mem_req_ready` both high. The first beat address is {high, low}. With increment on, the address steps by 1, 2, 4 or 8 bytes after each beat; with increment off it stays fixed. `mem_req_size` equals the width field. `mem_req_write` is 1 for direction 1 and 0 for direction 0. The request holds steady while ready is low.
- R6: The done flag is bit 0 of index 6 and also drives `xfer_done`. It is set on the clock edge of the last beat, or on the start edge when the count is 0, in which case no beat is issued. It stays set until a write to index 6 with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set. Bit 1 of index 6 shows busy.
- R7: While a transfer runs, a further start is ignored, and writes to indices 0, 3, 4 and 5 are ignored.
- R8: A start is refused, with no beat and no done, if any of these holds: the low address is not a multiple of the beat size, the direction is 2 or 3, or the channel of that direction is held in reset. Channel 0 is bit 8 of index 2 and serves direction 0. Channel 1 is bit 9 and serves direction 1.
- R9: Clearing the channel bit of the running direction drops `mem_req_valid` from the cycle after that write's edge. No further beat is issued, done is set on the next edge, and the engine goes idle. Clearing only the other channel's bit has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Beat request valid |
| mem_req_ready | input | 1 | Beat accepted by memory side |
| mem_req_addr | output | 64 | Beat byte address |
| mem_req_write | output | 1 | 1 when the beat writes memory (card to memory) |
| mem_req_size | output | 2 | Beat width code |
| xfer_done | output | 1 | Sticky completion flag |

## Verification
Register writes take effect on the clock edge where `wr_en` is sampled, and reads are combinational. So a readback, a new `mem_req_valid` level or a set done flag can be observed half a cycle after the write edge. An abort shows up as valid low in that same next cycle, with done following one edge later. A reference model in the bench applies the same edge-by-edge rules from the requirements. It is compared against the outputs one nanosecond after every rising edge, and inputs change only on falling edges. Directed checks on beat counts, busy, done and readback are sampled on falling edges after the edge that is due to produce them.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;

    localparam int REG_MODE = 0;
    localparam int REG_CTRL = 1;
    localparam int REG_CHRST = 2;
    localparam int REG_ADDR_LO = 3;
    localparam int REG_ADDR_HI = 4;
    localparam int REG_COUNT = 5;
    localparam int REG_STATUS = 6;

    localparam int MODE_DIR_LSB = 16;
    localparam int MODE_WID_LSB = 4;
    localparam int MODE_INC_BIT = 0;
    localparam int CHRST_LSB = 8;

    function automatic logic [3:0] beat_bytes(input logic [1:0] width);
        return 4'd1 << width;
    endfunction

    function automatic logic addr_aligned(input logic [2:0] lo, input logic [1:0] width);
        logic ok;
        case (width)
            2'd0: ok = 1'b1;
            2'd1: ok = (lo[0] == 1'b0);
            2'd2: ok = (lo[1:0] == 2'b00);
            default: ok = (lo == 3'b000);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sdma_regs.sv
`timescale 1ns/1ps
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16,
    parameter int RA_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [RA_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [RA_W-1:0]       rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    input  logic                  busy_i,
    input  logic                  finish_i,
    output logic                  start_o,
    output logic                  dir_o,
    output logic [1:0]            width_o,
    output logic                  inc_o,
    output logic [2*WORD_W-1:0]   addr_o,
    output logic [LEN_W-1:0]      len_o,
    output logic [1:0]            chan_rel_o,
    output logic                  done_o
);

    typedef struct packed {
        logic [1:0]        dir;
        logic [1:0]        width;
        logic              inc;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [LEN_W-1:0]  len;
        logic [1:0]        rel;
        logic              done;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  start_d;
    logic  hit_mode, hit_ctrl, hit_chrst, hit_lo, hit_hi, hit_cnt, hit_stat;

    always_comb begin
        hit_mode  = wr_en && (wr_addr == RA_W'(REG_MODE));
        hit_ctrl  = wr_en && (wr_addr == RA_W'(REG_CTRL));
        hit_chrst = wr_en && (wr_addr == RA_W'(REG_CHRST));
        hit_lo    = wr_en && (wr_addr == RA_W'(REG_ADDR_LO));
        hit_hi    = wr_en && (wr_addr == RA_W'(REG_ADDR_HI));
        hit_cnt   = wr_en && (wr_addr == RA_W'(REG_COUNT));
        hit_stat  = wr_en && (wr_addr == RA_W'(REG_STATUS));

        regs_d  = regs_q;
        start_d = 1'b0;

        if (!busy_i) begin
            if (hit_mode) begin
                regs_d.dir   = wr_data[MODE_DIR_LSB +: 2];
                regs_d.width = wr_data[MODE_WID_LSB +: 2];
                regs_d.inc   = wr_data[MODE_INC_BIT];
            end
            if (hit_lo)  regs_d.lo  = wr_data;
            if (hit_hi)  regs_d.hi  = wr_data;
            if (hit_cnt) regs_d.len = wr_data[LEN_W-1:0];
            if (hit_ctrl && wr_data[0] && !regs_q.dir[1]
                && addr_aligned(regs_q.lo[2:0], regs_q.width)
                && regs_q.rel[regs_q.dir[0]]) begin
                start_d = 1'b1;
            end
        end

        if (hit_chrst) regs_d.rel = wr_data[CHRST_LSB +: 2];
        if (hit_stat && wr_data[0]) regs_d.done = 1'b0;
        if (finish_i) regs_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.rel <= 2'b11;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_W'(REG_MODE): begin
                rd_data[MODE_DIR_LSB +: 2] = regs_q.dir;
                rd_data[MODE_WID_LSB +: 2] = regs_q.width;
                rd_data[MODE_INC_BIT]      = regs_q.inc;
            end
            RA_W'(REG_CTRL):    rd_data[0] = busy_i;
            RA_W'(REG_CHRST):   rd_data[CHRST_LSB +: 2] = regs_q.rel;
            RA_W'(REG_ADDR_LO): rd_data = regs_q.lo;
            RA_W'(REG_ADDR_HI): rd_data = regs_q.hi;
            RA_W'(REG_COUNT):   rd_data[LEN_W-1:0] = regs_q.len;
            RA_W'(REG_STATUS):  rd_data[1:0] = {busy_i, regs_q.done};
            default:            rd_data = '0;
        endcase
    end

    assign start_o    = start_d;
    assign dir_o      = regs_q.dir[0];
    assign width_o    = regs_q.width;
    assign inc_o      = regs_q.inc;
    assign addr_o     = {regs_q.hi, regs_q.lo};
    assign len_o      = regs_q.len;
    assign chan_rel_o = regs_q.rel;
    assign done_o     = regs_q.done;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en && wr_addr != RA_W'(REG_CTRL) && wr_addr != RA_W'(REG_CHRST)
         && wr_addr != RA_W'(REG_STATUS))
        |=> $stable({regs_q.dir, regs_q.width, regs_q.inc, regs_q.lo, regs_q.hi, regs_q.len})); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.done && !(hit_stat && wr_data[0])) |=> regs_q.done); // R6

endmodule

// File: rtl/sdma_seq.sv
`timescale 1ns/1ps
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [1:0]        width_i,
    input  logic              inc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        chan_rel_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              write_o,
    output logic [1:0]        size_o,
    output logic              busy_o,
    output logic              finish_o
);

    typedef struct packed {
        logic              run;
        logic              dir;
        logic [1:0]        width;
        logic              inc;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
    } seq_t;

    seq_t seq_d, seq_q;
    logic chan_ok, fire, fin;
    logic [ADDR_W-1:0] step;

    always_comb begin
        chan_ok = chan_rel_i[seq_q.dir];
        fire    = seq_q.run && chan_ok && ready_i;
        step    = seq_q.inc ? {{(ADDR_W-4){1'b0}}, beat_bytes(seq_q.width)} : '0;
        seq_d   = seq_q;
        fin     = 1'b0;

        if (seq_q.run) begin
            if (!chan_ok) begin
                seq_d.run = 1'b0;
                fin       = 1'b1;
            end else if (ready_i) begin
                seq_d.addr = seq_q.addr + step;
                seq_d.rem  = seq_q.rem - 1'b1;
                if (seq_q.rem == LEN_W'(1)) begin
                    seq_d.run = 1'b0;
                    fin       = 1'b1;
                end
            end
        end else if (start_i) begin
            if (len_i == '0) begin
                fin = 1'b1;
            end else begin
                seq_d.run   = 1'b1;
                seq_d.dir   = dir_i;
                seq_d.width = width_i;
                seq_d.inc   = inc_i;
                seq_d.addr  = addr_i;
                seq_d.rem   = len_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign valid_o  = seq_q.run && chan_ok;
    assign addr_o   = seq_q.addr;
    assign write_o  = seq_q.dir;
    assign size_o   = seq_q.width;
    assign busy_o   = seq_q.run;
    assign finish_o = fin;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> ($stable(seq_q.addr) && $stable(seq_q.rem))); // R5

    AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !seq_q.inc) |=> $stable(seq_q.addr)); // R5

    AST_LAST_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && seq_q.rem == LEN_W'(1)) |=> !valid_o); // R6

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && !chan_ok) |=> !seq_q.run); // R9

endmodule

// File: rtl/sdma_ctrl.sv
`timescale 1ns/1ps
module sdma_ctrl
    import sdma_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16,
    parameter int RA_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RA_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [RA_W-1:0]      rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [2*WORD_W-1:0]  mem_req_addr,
    output logic                 mem_req_write,
    output logic [1:0]           mem_req_size,
    output logic                 xfer_done
);

    localparam int ADDR_W = 2 * WORD_W;

    logic              start, dir, inc, busy, finish;
    logic [1:0]        width, chan_rel;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;

    sdma_regs #(.WORD_W(WORD_W), .LEN_W(LEN_W), .RA_W(RA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy_i     (busy),
        .finish_i   (finish),
        .start_o    (start),
        .dir_o      (dir),
        .width_o    (width),
        .inc_o      (inc),
        .addr_o     (base),
        .len_o      (len),
        .chan_rel_o (chan_rel),
        .done_o     (xfer_done)
    );

    sdma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dir_i      (dir),
        .width_i    (width),
        .inc_i      (inc),
        .addr_i     (base),
        .len_i      (len),
        .chan_rel_i (chan_rel),
        .ready_i    (mem_req_ready),
        .valid_o    (mem_req_valid),
        .addr_o     (mem_req_addr),
        .write_o    (mem_req_write),
        .size_o     (mem_req_size),
        .busy_o     (busy),
        .finish_o   (finish)
    );

    AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> addr_aligned(mem_req_addr[2:0], mem_req_size)); // R8

    AST_DONE_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> xfer_done); // R6

endmodule

// File: tb/sim_sdma_ctrl.sv
`timescale 1ns/1ps
module sim_sdma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_req_write;
    logic [1:0]  mem_req_size;
    logic        xfer_done;

    always #2.5 clk = ~clk;

    sdma_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_write(mem_req_write), .mem_req_size(mem_req_size), .xfer_done(xfer_done)
    );

    int total = 0;
    int bad = 0;
    int dut_beats = 0;
    int rpat = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready pattern generator
    always @(negedge clk) begin
        cyc++;
        case (rpat)
            0: mem_req_ready <= 1'b1;
            1: mem_req_ready <= cyc[0];
            default: mem_req_ready <= (cyc % 3 == 0);
        endcase
    end

    always @(posedge clk)
        if (rst_n && mem_req_valid && mem_req_ready) dut_beats++;

    // behavioural reference model
    bit [1:0]  m_dir, m_wid, m_rst;
    bit        m_inc, m_done, m_busy;
    bit [31:0] m_alo, m_ahi;
    bit [15:0] m_len;
    bit [63:0] m_cur;
    int        m_rem;
    bit        m_rdir, m_rinc;
    bit [1:0]  m_rwid;

    function automatic bit m_valid();
        return m_busy && m_rst[m_rdir];
    endfunction

    function automatic bit [31:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return {14'b0, m_dir, 10'b0, m_wid, 3'b0, m_inc};
            3'd1: return {31'b0, m_busy};
            3'd2: return {22'b0, m_rst, 8'b0};
            3'd3: return m_alo;
            3'd4: return m_ahi;
            3'd5: return {16'b0, m_len};
            3'd6: return {30'b0, m_busy, m_done};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_wid = 0; m_inc = 0; m_alo = 0; m_ahi = 0; m_len = 0;
            m_rst = 2'b11; m_done = 0; m_busy = 0; m_cur = 0; m_rem = 0;
            m_rdir = 0; m_rinc = 0; m_rwid = 0;
        end else begin
            bit fin;
            bit ob;
            fin = 0;
            ob = m_busy;
            if (ob) begin
                if (!m_rst[m_rdir]) begin
                    m_busy = 0; fin = 1;
                end else if (mem_req_ready) begin
                    if (m_rinc) m_cur = m_cur + (64'd1 << m_rwid);
                    m_rem--;
                    if (m_rem == 0) begin m_busy = 0; fin = 1; end
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: if (!ob) begin
                        m_dir = wr_data[17:16]; m_wid = wr_data[5:4]; m_inc = wr_data[0];
                    end
                    3'd1: if (!ob && wr_data[0] && m_dir < 2
                              && ((m_alo & ((32'd1 << m_wid) - 1)) == 0) && m_rst[m_dir[0]]) begin
                        if (m_len == 0) fin = 1;
                        else begin
                            m_busy = 1; m_rem = m_len; m_cur = {m_ahi, m_alo};
                            m_rdir = m_dir[0]; m_rwid = m_wid; m_rinc = m_inc;
                        end
                    end
                    3'd2: m_rst = wr_data[9:8];
                    3'd3: if (!ob) m_alo = wr_data;
                    3'd4: if (!ob) m_ahi = wr_data;
                    3'd5: if (!ob) m_len = wr_data[15:0];
                    3'd6: if (wr_data[0]) m_done = 0;
                    default: ;
                endcase
            end
            if (fin) m_done = 1;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R5 valid", {63'b0, mem_req_valid}, {63'b0, m_valid()});
            if (mem_req_valid && m_valid()) begin
                check("R5 addr", mem_req_addr, m_cur);
                check("R5 write", {63'b0, mem_req_write}, {63'b0, m_rdir});
                check("R5 size", {62'b0, mem_req_size}, {62'b0, m_rwid});
            end
            check("R6 done", {63'b0, xfer_done}, {63'b0, m_done});
            check("R2 readback", {32'b0, rd_data}, {32'b0, m_read(rd_addr)});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600 && !xfer_done; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd2, v); check("R1 chrst", {32'b0, v}, 64'h300);
        rd(3'd0, v); check("R1 mode", {32'b0, v}, 64'h0);
        rd(3'd6, v); check("R1 status", {32'b0, v}, 64'h0);
        check("R1 valid", {63'b0, mem_req_valid}, 64'h0);
        check("R1 done", {63'b0, xfer_done}, 64'h0);

        // memory to card, 64-bit, increment
        rpat = 0;
        wr(3'd3, 32'h0000_0008); wr(3'd4, 32'h0000_0001); wr(3'd5, 32'd4);
        wr(3'd0, 32'h0000_0031);
        rd(3'd3, v); check("R3 lo", {32'b0, v}, 64'h8);
        rd(3'd4, v); check("R3 hi", {32'b0, v}, 64'h1);
        rd(3'd5, v); check("R3 count", {32'b0, v}, 64'h4);
        rd(3'd0, v); check("R2 mode", {32'b0, v}, 64'h31);
        b = dut_beats;
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R4 busy", {32'b0, v}, 64'h1);
        check("R4 valid", {63'b0, mem_req_valid}, 64'h1);
        wait_done();
        check("R5 beats64", dut_beats - b, 4);
        rd(3'd1, v); check("R4 selfclear", {32'b0, v}, 64'h0);
        wr(3'd6, 32'h1);
        check("R6 clear", {63'b0, xfer_done}, 64'h0);

        // card to memory, 8-bit, fixed, stalling ready
        rpat = 1;
        wr(3'd0, 32'h0001_0000); wr(3'd3, 32'h13); wr(3'd5, 32'd3);
        b = dut_beats;
        wr(3'd1, 32'h1);
        wait_done();
        check("R5 beats8", dut_beats - b, 3);
        wr(3'd6, 32'h0);
        check("R6 w0 keeps", {63'b0, xfer_done}, 64'h1);
        wr(3'd6, 32'h1);
        check("R6 w1 clears", {63'b0, xfer_done}, 64'h0);

        // 16-bit increment, writes during busy ignored
        rpat = 2;
        wr(3'd0, 32'h0000_0011); wr(3'd3, 32'h102); wr(3'd5, 32'd5);
        b = dut_beats;
        wr(3'd1, 32'h1);
        wr(3'd1, 32'h1);
        wr(3'd0, 32'h0001_0030);
        wr(3'd3, 32'hAAA0);
        rd(3'd0, v); check("R7 mode frozen", {32'b0, v}, 64'h11);
        rd(3'd3, v); check("R7 lo frozen", {32'b0, v}, 64'h102);
        wait_done();
        check("R7 beats", dut_beats - b, 5);
        wr(3'd6, 32'h1);

        // refused starts
        rpat = 0;
        wr(3'd0, 32'h0000_0021);
        b = dut_beats;
        wr(3'd1, 32'h1);
        repeat (4) @(negedge clk);
        check("R8 misaligned beats", dut_beats - b, 0);
        check("R8 misaligned done", {63'b0, xfer_done}, 64'h0);
        wr(3'd0, 32'h0002_0000);
        wr(3'd1, 32'h1);
        repeat (4) @(negedge clk);
        check("R8 reserved dir beats", dut_beats - b, 0);
        check("R8 reserved dir done", {63'b0, xfer_done}, 64'h0);
        wr(3'd2, 32'h200);
        wr(3'd0, 32'h0000_0000);
        wr(3'd1, 32'h1);
        repeat (4) @(negedge clk);
        check("R8 held channel beats", dut_beats - b, 0);
        wr(3'd0, 32'h0001_0000); wr(3'd5, 32'd2);
        wr(3'd1, 32'h1);
        wait_done();
        check("R8 other channel runs", dut_beats - b, 2);
        wr(3'd6, 32'h1); wr(3'd2, 32'h300);

        // abort
        rpat = 1;
        wr(3'd0, 32'h0000_0031); wr(3'd3, 32'h40); wr(3'd5, 32'd100);
        wr(3'd1, 32'h1);
        repeat (6) @(negedge clk);
        wr(3'd2, 32'h100);
        rd(3'd1, v); check("R9 other channel no effect", {32'b0, v}, 64'h1);
        check("R9 no done yet", {63'b0, xfer_done}, 64'h0);
        wr(3'd2, 32'h000);
        b = dut_beats;
        check("R9 valid drops", {63'b0, mem_req_valid}, 64'h0);
        repeat (3) @(negedge clk);
        check("R9 no more beats", dut_beats - b, 0);
        check("R9 done", {63'b0, xfer_done}, 64'h1);
        rd(3'd1, v); check("R9 idle", {32'b0, v}, 64'h0);
        wr(3'd2, 32'h300); wr(3'd6, 32'h1);

        // zero-length
        wr(3'd5, 32'd0);
        b = dut_beats;
        wr(3'd1, 32'h1);
        check("R6 zero length done", {63'b0, xfer_done}, 64'h1);
        repeat (3) @(negedge clk);
        check("R6 zero length beats", dut_beats - b, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule